// File: doc/BRIEF.md
# Out-of-Band COM Sequence Detector

This block watches the electrical-idle (squelch) indication of a serial receiver. It finds the out-of-band signalling sequences that a serial ATA link uses during start-up. A high squelch level means the line is idle, and a low level means a burst of signal is present. The block runs on a slow squelch clock. It brings the squelch flag into that domain through a two-flop synchronizer. It then measures every burst and every idle gap as a count of clock cycles.

Each burst length is checked against a programmable window. Each idle gap is sorted into one of two kinds: the long reset/initialise gap or the short wake gap. Each kind has its own inclusive minimum/maximum window. Valid bursts and qualifying idles are tallied. The idle tally restarts whenever the idle kind changes. When both tallies reach their programmed targets, the block emits a one-cycle pulse on the output for that idle kind, then starts hunting again from scratch. Typical settings are 4 bursts, 3 idles, a burst window of 1..7, a wake window of 3..7 and a reset/initialise window of 12..22. Every maximum must be strictly greater than its minimum.

Top module: `oob_com_detect`

## Requirements
- R1: While rst_n is low at a clock edge, both detection outputs go low and all tallies clear. The first idle run after reset is never counted, because it does not follow a valid burst.
- R2: The squelch input passes through a two-flop synchronizer. A level held for N clock cycles at the input is measured as a run of exactly N cycles.
- R3: A burst is valid when cfg_burst_min <= length <= cfg_burst_max, both limits inclusive. A burst outside that window clears both tallies.
- R4: An idle that follows a valid burst is of the reset/initialise kind when cfg_init_min <= length <= cfg_init_max. Otherwise it is of the wake kind when cfg_wake_min <= length <= cfg_wake_max. The reset/initialise window has priority.
- R5: An idle that follows a valid burst and falls in neither window clears both tallies.
- R6: When a qualifying idle differs in kind from the idles counted so far, the idle tally restarts at 1 with the new kind.
- R7: After every burst end and every idle end, the block declares a match if the burst tally >= cfg_burst_need and the idle tally >= cfg_idle_need. A match gives a one-cycle pulse on init_det (reset/initialise kind) or on wake_det (wake kind).
- R8: A match clears both tallies. The idle after the matching burst is ignored, and hunting resumes with the next burst.
- R9: Run-length measurement saturates at 63 cycles. A long run never wraps into a qualifying length.
- R10: init_det and wake_det are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Squelch-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sq_idle | input | 1 | Asynchronous squelch flag, high = line idle |
| cfg_burst_min | input | 6 | Shortest valid burst, in cycles |
| cfg_burst_max | input | 6 | Longest valid burst, in cycles |
| cfg_init_min | input | 6 | Shortest reset/initialise idle |
| cfg_init_max | input | 6 | Longest reset/initialise idle |
| cfg_wake_min | input | 6 | Shortest wake idle |
| cfg_wake_max | input | 6 | Longest wake idle |
| cfg_burst_need | input | 3 | Valid bursts needed for a match |
| cfg_idle_need | input | 3 | Qualifying idles needed for a match |
| init_det | output | 1 | One-cycle reset/initialise sequence pulse |
| wake_det | output | 1 | One-cycle wake sequence pulse |

## Verification
On every cycle, the assertions check that:
- the two pulses are exclusive and last a single cycle;
- a rejected burst or an unclassifiable idle empties the tallies;
- a match leaves the tallies empty;
- a kind change restarts the idle tally at one;
- the run counter holds at its ceiling.

Only the bench's scenarios can show that a complete, correctly timed sequence produces exactly one pulse of the right kind. They also show that window boundaries are inclusive, that mixed and interrupted sequences do not match, and that a 70-cycle idle does not alias into the wake window.

// File: rtl/oob_pkg.sv
// Shared types for the out-of-band COM detector.
package oob_pkg;
    // Kind of a qualifying idle gap
    typedef enum logic {
        GAP_INIT = 1'b0,
        GAP_WAKE = 1'b1
    } gap_kind_t;
endpackage

// File: rtl/oob_sync.sv
// Multi-flop synchronizer for the squelch flag.
// Assumes: the input is asynchronous and slow compared with clk. It resets to 1 (idle).
module oob_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/oob_run_meter.sv
// Measures the length of each constant-level run of the synchronized squelch flag.
// An end-of-run strobe and the saturating length appear in the cycle the level changes.
// Assumes: the level resets to idle (1). The length saturates at all-ones.
module oob_run_meter #(
    parameter int DUR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    output logic             burst_end,
    output logic             idle_end,
    output logic [DUR_W-1:0] run_len
);
    localparam logic [DUR_W-1:0] DUR_CEIL = '1;

    logic             lvl_d;
    logic [DUR_W-1:0] cnt;
    logic             change;

    assign change    = (lvl != lvl_d);
    assign burst_end = change &  lvl;
    assign idle_end  = change & ~lvl;
    assign run_len   = cnt;

    // track the previous level and count cycles spent at it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d <= 1'b1;
            cnt   <= '0;
        end else begin
            lvl_d <= lvl;
            if (change)               cnt <= {{(DUR_W-1){1'b0}}, 1'b1};
            else if (cnt != DUR_CEIL) cnt <= cnt + 1'b1;
        end
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == DUR_CEIL && !change) |=> (cnt == DUR_CEIL));
endmodule

// File: rtl/oob_seq.sv
// Tallies valid bursts and classified idles and declares a COM match.
// Assumes: burst_end and idle_end never occur in the same cycle, and each max exceeds its min.
module oob_seq
    import oob_pkg::*;
#(
    parameter int DUR_W   = 6,
    parameter int TALLY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               burst_end,
    input  logic               idle_end,
    input  logic [DUR_W-1:0]   run_len,
    input  logic [DUR_W-1:0]   burst_min,
    input  logic [DUR_W-1:0]   burst_max,
    input  logic [DUR_W-1:0]   init_min,
    input  logic [DUR_W-1:0]   init_max,
    input  logic [DUR_W-1:0]   wake_min,
    input  logic [DUR_W-1:0]   wake_max,
    input  logic [TALLY_W-1:0] burst_need,
    input  logic [TALLY_W-1:0] idle_need,
    output logic               det_init,
    output logic               det_wake
);
    localparam logic [TALLY_W-1:0] TALLY_CEIL = '1;

    logic [TALLY_W-1:0] burst_cnt, idle_cnt, nb, ni;
    gap_kind_t          kind, nk;
    logic               armed, narm;
    logic               burst_ok, init_ok, wake_ok;
    logic               check, hit, clr;

    assign burst_ok = (run_len >= burst_min) && (run_len <= burst_max);
    assign init_ok  = (run_len >= init_min)  && (run_len <= init_max);
    assign wake_ok  = (run_len >= wake_min)  && (run_len <= wake_max);

    // next-state of the tallies and the match decision
    always_comb begin
        nb    = burst_cnt;
        ni    = idle_cnt;
        nk    = kind;
        narm  = armed;
        check = 1'b0;
        clr   = 1'b0;
        if (burst_end) begin
            if (burst_ok) begin
                nb    = (burst_cnt == TALLY_CEIL) ? burst_cnt : burst_cnt + 1'b1;
                narm  = 1'b1;
                check = 1'b1;
            end else begin
                clr = 1'b1;
            end
        end else if (idle_end && armed) begin
            narm = 1'b0;
            if (init_ok || wake_ok) begin
                nk    = init_ok ? GAP_INIT : GAP_WAKE;
                check = 1'b1;
                if (idle_cnt != '0 && kind != nk)
                    ni = {{(TALLY_W-1){1'b0}}, 1'b1};
                else
                    ni = (idle_cnt == TALLY_CEIL) ? idle_cnt : idle_cnt + 1'b1;
            end else begin
                clr = 1'b1;
            end
        end
        hit = check && (nb >= burst_need) && (ni >= idle_need);
        if (hit || clr) begin
            nb   = '0;
            ni   = '0;
            narm = 1'b0;
        end
    end

    // register the tallies and the detection pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_cnt <= '0;
            idle_cnt  <= '0;
            kind      <= GAP_INIT;
            armed     <= 1'b0;
            det_init  <= 1'b0;
            det_wake  <= 1'b0;
        end else begin
            burst_cnt <= nb;
            idle_cnt  <= ni;
            kind      <= nk;
            armed     <= narm;
            det_init  <= hit && (nk == GAP_INIT);
            det_wake  <= hit && (nk == GAP_WAKE);
        end
    end

    // R3
    bad_burst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_end && run_len > burst_max) |=> (burst_cnt == '0 && idle_cnt == '0));
    // R5
    bad_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_end && armed && run_len > init_max && run_len > wake_max)
        |=> (burst_cnt == '0 && idle_cnt == '0));
    // R6
    kind_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_end && armed && idle_cnt != '0 && kind == GAP_INIT && !init_ok && wake_ok
         && idle_need > 3'd1) |=> (idle_cnt == 3'd1));
    // R8
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_init || det_wake) |-> (burst_cnt == '0 && idle_cnt == '0 && !armed));
    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_init || det_wake) |=> !(det_init || det_wake));
endmodule

// File: rtl/oob_com_detect.sv
// Top level: squelch synchronizer, run-length meter and COM sequence tally.
// Assumes: clk is the slow squelch clock, and sq_idle is high while the line is idle.
module oob_com_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int DUR_W       = 6,
    parameter int TALLY_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sq_idle,
    input  logic [DUR_W-1:0]   cfg_burst_min,
    input  logic [DUR_W-1:0]   cfg_burst_max,
    input  logic [DUR_W-1:0]   cfg_init_min,
    input  logic [DUR_W-1:0]   cfg_init_max,
    input  logic [DUR_W-1:0]   cfg_wake_min,
    input  logic [DUR_W-1:0]   cfg_wake_max,
    input  logic [TALLY_W-1:0] cfg_burst_need,
    input  logic [TALLY_W-1:0] cfg_idle_need,
    output logic               init_det,
    output logic               wake_det
);
    logic             sq_s;
    logic             burst_end, idle_end;
    logic [DUR_W-1:0] run_len;

    oob_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(sq_idle), .q_sync(sq_s)
    );

    oob_run_meter #(.DUR_W(DUR_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .lvl(sq_s),
        .burst_end(burst_end), .idle_end(idle_end), .run_len(run_len)
    );

    oob_seq #(.DUR_W(DUR_W), .TALLY_W(TALLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .burst_end(burst_end), .idle_end(idle_end), .run_len(run_len),
        .burst_min(cfg_burst_min), .burst_max(cfg_burst_max),
        .init_min(cfg_init_min), .init_max(cfg_init_max),
        .wake_min(cfg_wake_min), .wake_max(cfg_wake_max),
        .burst_need(cfg_burst_need), .idle_need(cfg_idle_need),
        .det_init(init_det), .det_wake(wake_det)
    );

    // R10
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_det, wake_det}));
endmodule

// File: tb/tb_oob_com_detect.sv
module tb_oob_com_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sq_idle = 1'b1;
    logic [5:0] bmin, bmax, imin, imax, wmin, wmax;
    logic [2:0] bneed, ineed;
    logic       init_det, wake_det;
    int         checks = 0, errors = 0;
    int         n_init = 0, n_wake = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    oob_com_detect dut (
        .clk(clk), .rst_n(rst_n), .sq_idle(sq_idle),
        .cfg_burst_min(bmin), .cfg_burst_max(bmax),
        .cfg_init_min(imin), .cfg_init_max(imax),
        .cfg_wake_min(wmin), .cfg_wake_max(wmax),
        .cfg_burst_need(bneed), .cfg_idle_need(ineed),
        .init_det(init_det), .wake_det(wake_det)
    );

    // count pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n && init_det) n_init++;
        if (rst_n && wake_det) n_wake++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic defaults();
        bmin = 6'd1;  bmax = 6'd7;
        imin = 6'd12; imax = 6'd22;
        wmin = 6'd3;  wmax = 6'd7;
        bneed = 3'd4; ineed = 3'd3;
    endtask

    task automatic level(input bit v, input int n);
        sq_idle = v;
        repeat (n) @(negedge clk);
    endtask

    // a long idle: lets pulses emerge, then clears tallies when it ends
    task automatic settle();
        level(1'b1, 40);
    endtask

    task automatic seq(input int nb, input int blen, input int ilen);
        for (int k = 0; k < nb; k++) begin
            level(1'b0, blen);
            if (k != nb - 1) level(1'b1, ilen);
        end
        settle();
    endtask

    task automatic expect_counts(input string req, input int di, input int dw,
                                 input int i0, input int w0);
        check(n_init - i0 == di, {req, " init pulses"}, n_init - i0, di);
        check(n_wake - w0 == dw, {req, " wake pulses"}, n_wake - w0, dw);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(init_det == 1'b0 && wake_det == 1'b0, "R1 outputs in reset",
              {init_det, wake_det}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_idle();   // R1: the first idle after reset is not counted
        int i0, w0;
        t_reset();
        i0 = n_init; w0 = n_wake;
        bneed = 3'd3;
        level(1'b1, 16);
        seq(3, 4, 16);
        expect_counts("R1", 0, 0, i0, w0);
        defaults();
    endtask

    task automatic t_init_match();   // R2 R4 R7
        int i0 = n_init, w0 = n_wake;
        seq(4, 4, 16);
        expect_counts("R7", 1, 0, i0, w0);
    endtask

    task automatic t_wake_match();   // R4 R7 R10
        int i0 = n_init, w0 = n_wake;
        seq(4, 4, 5);
        expect_counts("R10", 0, 1, i0, w0);
    endtask

    task automatic t_burst_bounds(); // R3
        int i0 = n_init, w0 = n_wake;
        seq(4, 7, 16);
        expect_counts("R3 burst at max", 1, 0, i0, w0);
        i0 = n_init;
        level(1'b0, 4); level(1'b1, 16); level(1'b0, 8); level(1'b1, 16);
        level(1'b0, 4); level(1'b1, 16); level(1'b0, 4); settle();
        expect_counts("R3 long burst", 0, 0, i0, w0);
        i0 = n_init;
        bmin = 6'd3;
        seq(4, 2, 16);
        expect_counts("R3 short burst", 0, 0, i0, w0);
        defaults();
    endtask

    task automatic t_idle_bounds();  // R4 R5
        int i0 = n_init, w0 = n_wake;
        seq(4, 4, 22);
        expect_counts("R4 idle at max", 1, 0, i0, w0);
        i0 = n_init;
        seq(4, 4, 23);
        expect_counts("R5 idle above max", 0, 0, i0, w0);
        level(1'b0, 4); level(1'b1, 16); level(1'b0, 4); level(1'b1, 10);
        level(1'b0, 4); level(1'b1, 16); level(1'b0, 4); level(1'b1, 16);
        level(1'b0, 4); settle();
        expect_counts("R5 idle between windows", 0, 0, i0, w0);
    endtask

    task automatic t_kind_switch();  // R6
        int i0 = n_init, w0 = n_wake;
        level(1'b0, 4); level(1'b1, 16); level(1'b0, 4); level(1'b1, 5);
        level(1'b0, 4); level(1'b1, 16); level(1'b0, 4); level(1'b1, 16);
        level(1'b0, 4); level(1'b1, 16);
        check(n_init == i0 && n_wake == w0, "R6 no match after switch",
              n_init - i0 + n_wake - w0, 0);
        level(1'b0, 4); settle();
        expect_counts("R6 third idle of one kind", 1, 0, i0, w0);
    endtask

    task automatic t_restart();      // R8
        int i0 = n_init, w0 = n_wake;
        for (int k = 0; k < 7; k++) begin
            level(1'b0, 4);
            if (k != 6) level(1'b1, 16);
        end
        settle();
        expect_counts("R8 one match from seven bursts", 1, 0, i0, w0);
    endtask

    task automatic t_saturate();     // R9
        int i0 = n_init, w0 = n_wake;
        level(1'b0, 4); level(1'b1, 5); level(1'b0, 4); level(1'b1, 5);
        level(1'b0, 4); level(1'b1, 70); level(1'b0, 4); settle();
        expect_counts("R9 long idle does not wrap", 0, 0, i0, w0);
    endtask

    task automatic t_need_cfg();     // R7 programmable targets
        int i0 = n_init, w0 = n_wake;
        bneed = 3'd2; ineed = 3'd1;
        seq(2, 4, 5);
        expect_counts("R7 short targets", 0, 1, i0, w0);
        defaults();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        defaults();
        @(negedge clk);
        t_reset();
        settle();
        check(n_init == 0 && n_wake == 0, "R1 quiet after reset", n_init + n_wake, 0);
        t_init_match();
        t_wake_match();
        t_burst_bounds();
        t_idle_bounds();
        t_kind_switch();
        t_restart();
        t_saturate();
        t_need_cfg();
        t_first_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule